// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Status Aggregator

This block sits beside the register interface of a two-channel serial controller and turns each channel's receive, transmit and break conditions into one interrupt request per channel. Receive and transmit conditions are held as sticky flags. The register interface raises and lowers them with single-cycle set and clear pulses. Each flag is then masked by that channel's interrupt-control byte. The break condition comes straight from two register bits: a break-enable bit in the channel's extended control byte and a break-seen bit in its line status byte.

All four flags are also collected into one pending byte. The controller returns this byte when software reads it through channel A. The pending byte follows the flags combinationally, so a pending bit changes on the same clock edge as its flag. The request outputs are registered and are computed again on every cycle from the flags and control bytes present at that edge. A per-channel reset pulse clears only that channel's flags, pending bits and request.

Top module: `irq_status_aggr`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `pend_o` is 0x00 and both bits of `irq_o` are 0.
- R2: Layout of the pending byte:
  - bit 5 is channel A receive, bit 4 is channel A transmit, bit 2 is channel B receive and bit 1 is channel B transmit;
  - bits 7, 6, 3 and 0 read 0.
  - Index 0 of every per-channel vector is channel A and index 1 is channel B.
  - In every 16-bit bus, bits [7:0] belong to channel A and bits [15:8] to channel B.
- R3: A set pulse sampled at a clock edge makes its flag 1 from that edge on. The matching pending bit changes on the same edge.
- R4: A clear pulse on its own makes its flag 0 at the next edge. If a set pulse and a clear pulse for the same flag come in the same cycle, the flag becomes 1.
- R5: A channel's request stays 0 while bit 0 (master enable) of its control byte is 0, whatever its flags and break bits are.
- R6: With master enable set, the transmit source requests an interrupt when control bit 1 is 1 and the transmit flag is set.
- R7: With master enable set, the receive source requests an interrupt when control bits [4:3] are 01 or 10 and the receive flag is set. The values 00 and 11 mask it.
- R8: With master enable set, the break source requests an interrupt when bit 7 of the extended control byte and bit 7 of the line status byte are both 1.
- R9: `irq_o` is registered. At each edge it takes the value computed from the control inputs at that edge and the flags held before that edge. A newly set flag therefore shows on `irq_o` one edge after it shows on `pend_o`.
- R10: A channel reset pulse clears that channel's two flags and its request at the next edge. It takes priority over a set pulse in the same cycle. The other channel is left unchanged.
- R11: Events, control bytes and resets of one channel have no effect on the other channel's flags or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_set_i | input | 2 | Receive flag set pulse, per channel |
| rx_clr_i | input | 2 | Receive flag clear pulse, per channel |
| tx_set_i | input | 2 | Transmit flag set pulse, per channel |
| tx_clr_i | input | 2 | Transmit flag clear pulse, per channel |
| chan_rst_i | input | 2 | Channel reset pulse, per channel |
| int_ctrl_i | input | 16 | Interrupt-control bytes: bit 0 master enable, bit 1 transmit enable, bits [4:3] receive mode |
| ext_ctrl_i | input | 16 | Extended control bytes: bit 7 break interrupt enable |
| line_stat_i | input | 16 | Line status bytes: bit 7 break seen |
| irq_o | output | 2 | Registered interrupt request, per channel |
| pend_o | output | 8 | Shared pending byte |

## Verification
The bench builds the block with its default parameters: an 8-bit register width and the two-channel layout that the pending byte encodes. At that width every control bit the decode uses is reachable. This covers all four receive-mode values, the master and transmit enables, and bit 7 of both break bytes, for both channels. A reference model in the bench steps one cycle per stimulus. It exercises:
- set and clear collisions;
- channel resets that coincide with set pulses;
- the one-edge lag of the request behind the pending byte;
- a long run of random per-cycle stimulus across both channels.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int CH_N       = 2;
  localparam int REG_W      = 8;
  localparam int MEN_BIT    = 0;
  localparam int TXEN_BIT   = 1;
  localparam int RXM_LSB    = 3;
  localparam int RXM_W      = 2;
  localparam int BRK_EN_BIT = 7;
  localparam int BRK_ST_BIT = 7;

  typedef enum logic [RXM_W-1:0] {
    RXM_OFF   = 2'b00,
    RXM_FIRST = 2'b01,
    RXM_ALL   = 2'b10,
    RXM_SPEC  = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic rx;
    logic tx;
  } chan_flags_t;

  // fixed positions in the shared pending byte
  function automatic int rx_pos(input int ch);
    return (ch == 0) ? 5 : 2;
  endfunction

  function automatic int tx_pos(input int ch);
    return (ch == 0) ? 4 : 1;
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic chan_rst_i,
  output logic flag_o
);
  // priority: channel reset, then set, then clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (chan_rst_i) flag_o <= 1'b0;
    else if (set_i)      flag_o <= 1'b1;
    else if (clr_i)      flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_req_eval.sv
module irq_req_eval
  import irq_aggr_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] ctrl_i,
  input  logic [W-1:0] ext_i,
  input  logic [W-1:0] stat_i,
  input  chan_flags_t  flags_i,
  output logic         req_o
);
  rx_mode_e mode;
  logic     rx_en, rx_req, tx_req, brk_req;

  always_comb begin
    mode    = rx_mode_e'(ctrl_i[RXM_LSB +: RXM_W]);
    rx_en   = (mode == RXM_FIRST) || (mode == RXM_ALL);
    rx_req  = rx_en & flags_i.rx;
    tx_req  = ctrl_i[TXEN_BIT] & flags_i.tx;
    brk_req = ext_i[BRK_EN_BIT] & stat_i[BRK_ST_BIT];
    req_o   = ctrl_i[MEN_BIT] & (rx_req | tx_req | brk_req);
  end
endmodule

// File: rtl/irq_pend_pack.sv
module irq_pend_pack
  import irq_aggr_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = CH_N
) (
  input  chan_flags_t flags_i [N],
  output logic [W-1:0] pend_o
);
  always_comb begin
    pend_o = '0;
    for (int c = 0; c < N; c++) begin
      pend_o[rx_pos(c)] = flags_i[c].rx;
      pend_o[tx_pos(c)] = flags_i[c].tx;
    end
  end
endmodule

// File: rtl/irq_status_aggr.sv
module irq_status_aggr
  import irq_aggr_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = CH_N
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   rx_set_i,
  input  logic [N-1:0]   rx_clr_i,
  input  logic [N-1:0]   tx_set_i,
  input  logic [N-1:0]   tx_clr_i,
  input  logic [N-1:0]   chan_rst_i,
  input  logic [N*W-1:0] int_ctrl_i,
  input  logic [N*W-1:0] ext_ctrl_i,
  input  logic [N*W-1:0] line_stat_i,
  output logic [N-1:0]   irq_o,
  output logic [W-1:0]   pend_o
);
  chan_flags_t flags [N];
  logic [N-1:0] req_d;
  logic [N-1:0] irq_q;

  for (genvar c = 0; c < N; c++) begin : g_ch
    irq_flag_cell u_rx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (rx_set_i[c]),
      .clr_i      (rx_clr_i[c]),
      .chan_rst_i (chan_rst_i[c]),
      .flag_o     (flags[c].rx)
    );

    irq_flag_cell u_tx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (tx_set_i[c]),
      .clr_i      (tx_clr_i[c]),
      .chan_rst_i (chan_rst_i[c]),
      .flag_o     (flags[c].tx)
    );

    irq_req_eval #(.W(W)) u_eval (
      .ctrl_i  (int_ctrl_i[c*W +: W]),
      .ext_i   (ext_ctrl_i[c*W +: W]),
      .stat_i  (line_stat_i[c*W +: W]),
      .flags_i (flags[c]),
      .req_o   (req_d[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            irq_q[c] <= 1'b0;
      else if (chan_rst_i[c]) irq_q[c] <= 1'b0;
      else                    irq_q[c] <= req_d[c];
    end
  end

  irq_pend_pack #(.W(W), .N(N)) u_pack (
    .flags_i (flags),
    .pend_o  (pend_o)
  );

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_aggr_chk.sv
module irq_status_aggr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  rx_set_i,
  input logic [1:0]  rx_clr_i,
  input logic [1:0]  tx_set_i,
  input logic [1:0]  chan_rst_i,
  input logic [15:0] int_ctrl_i,
  input logic [1:0]  irq_o,
  input logic [7:0]  pend_o
);
  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_set_i[0] && rx_clr_i[0] && !chan_rst_i[0]) |=> pend_o[5]);

  // R4
  clr_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_clr_i[1] && !rx_set_i[1]) |=> !pend_o[2]);

  // R5
  master_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_ctrl_i[0] |=> !irq_o[0]);

  // R5
  master_mask_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_ctrl_i[8] |=> !irq_o[1]);

  // R6
  tx_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ctrl_i[0] && int_ctrl_i[1] && pend_o[4] && !chan_rst_i[0]) |=> irq_o[0]);

  // R10
  chan_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i[0] |=> (pend_o[5:4] == 2'b00) && !irq_o[0]);

  // R3
  tx_set_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_set_i[1] && !chan_rst_i[1]) |=> pend_o[1]);
endmodule

bind irq_status_aggr irq_status_aggr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_set_i   (rx_set_i),
  .rx_clr_i   (rx_clr_i),
  .tx_set_i   (tx_set_i),
  .chan_rst_i (chan_rst_i),
  .int_ctrl_i (int_ctrl_i),
  .irq_o      (irq_o),
  .pend_o     (pend_o)
);

// File: tb/tb_irq_status_aggr.sv
`timescale 1ns/1ps
module tb_irq_status_aggr;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0, crst = '0;
  logic [15:0] ctrl = '0, ectl = '0, stat = '0;
  logic [1:0]  irq;
  logic [7:0]  pend;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic m_rx [2];
  logic m_tx [2];

  logic [7:0] exp_pend_q [$];
  logic [1:0] exp_irq_q  [$];
  string      tag_q      [$];

  always #2.5 clk = ~clk;

  irq_status_aggr dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rx_set_i    (rx_set),
    .rx_clr_i    (rx_clr),
    .tx_set_i    (tx_set),
    .tx_clr_i    (tx_clr),
    .chan_rst_i  (crst),
    .int_ctrl_i  (ctrl),
    .ext_ctrl_i  (ectl),
    .line_stat_i (stat),
    .irq_o       (irq),
    .pend_o      (pend)
  );

  function automatic logic req_model(input logic [7:0] c, input logic [7:0] e,
                                     input logic [7:0] s, input logic rx, input logic tx);
    logic rx_ok;
    rx_ok = (c[4:3] == 2'b01) || (c[4:3] == 2'b10);
    return c[0] & ((c[1] & tx) | (rx_ok & rx) | (e[7] & s[7]));
  endfunction

  function automatic logic flag_model(input logic old, input logic s,
                                      input logic c, input logic r);
    if (r) return 1'b0;
    if (s) return 1'b1;
    if (c) return 1'b0;
    return old;
  endfunction

  task automatic step(input string tag, input logic [1:0] rs, input logic [1:0] rc,
                      input logic [1:0] ts, input logic [1:0] tc, input logic [1:0] cr,
                      input logic [15:0] ct, input logic [15:0] ec, input logic [15:0] st);
    logic [1:0] ei;
    logic [7:0] ep;
    @(negedge clk);
    rx_set = rs; rx_clr = rc; tx_set = ts; tx_clr = tc; crst = cr;
    ctrl = ct; ectl = ec; stat = st;
    for (int c = 0; c < 2; c++) begin
      ei[c] = cr[c] ? 1'b0 : req_model(ct[c*8 +: 8], ec[c*8 +: 8], st[c*8 +: 8], m_rx[c], m_tx[c]);
      m_rx[c] = flag_model(m_rx[c], rs[c], rc[c], cr[c]);
      m_tx[c] = flag_model(m_tx[c], ts[c], tc[c], cr[c]);
    end
    ep = {2'b00, m_rx[0], m_tx[0], 1'b0, m_rx[1], m_tx[1], 1'b0};
    exp_pend_q.push_back(ep);
    exp_irq_q.push_back(ei);
    tag_q.push_back(tag);
  endtask

  // monitor: compare one expected item per edge
  always @(posedge clk) begin
    #1;
    if (exp_pend_q.size() > 0) begin
      logic [7:0] ep;
      logic [1:0] ei;
      string t;
      ep = exp_pend_q.pop_front();
      ei = exp_irq_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (pend !== ep || irq !== ei) begin
        fails++;
        $display("FAIL %s: pend=%02h irq=%b expected pend=%02h irq=%b", t, pend, irq, ep, ei);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_rx[c] = 0; m_tx[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (pend !== 8'h00 || irq !== 2'b00) begin
      fails++;
      $display("FAIL R1: pend=%02h irq=%b expected pend=00 irq=00", pend, irq);
    end

    // flag set and pending layout
    step("R3", 2'b01, 0, 0, 0, 0, 16'h0000, 0, 0);
    step("R2", 0, 0, 2'b01, 0, 0, 16'h0000, 0, 0);
    step("R2", 2'b10, 0, 2'b10, 0, 0, 16'h0000, 0, 0);
    // transmit enable and master mask
    step("R6", 0, 0, 0, 0, 0, 16'h0003, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 16'h0003, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 16'h001A, 16'h0080, 16'h0080);
    step("R5", 0, 0, 0, 0, 0, 16'h001A, 16'h0080, 16'h0080);
    // receive mode decode
    step("R4", 0, 0, 0, 2'b01, 0, 16'h0009, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 16'h0019, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 16'h0011, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 16'h0001, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 16'h0009, 0, 0);
    // set/clear collision
    step("R4", 0, 2'b01, 0, 0, 0, 16'h0000, 0, 0);
    step("R4", 2'b01, 2'b01, 0, 0, 0, 16'h0000, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 16'h0000, 0, 0);
    // break source
    step("R8", 0, 2'b01, 0, 0, 0, 16'h0001, 16'h0080, 16'h0080);
    step("R8", 0, 0, 0, 0, 0, 16'h0001, 16'h0080, 16'h0000);
    step("R8", 0, 0, 0, 0, 0, 16'h0001, 16'h0000, 16'h0080);
    step("R8", 0, 0, 0, 0, 0, 16'h0001, 16'h0080, 16'h0080);
    // registered request lags the flag by one edge
    step("R9", 0, 0, 2'b01, 0, 0, 16'h0003, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 16'h0003, 0, 0);
    // channel reset beats a coincident set; B untouched
    step("R10", 2'b01, 0, 2'b01, 0, 2'b01, 16'h0303, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 16'h0303, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 16'h0300, 0, 0);
    step("R11", 2'b01, 0, 0, 0, 0, 16'h0000, 0, 0);
    step("R10", 0, 0, 0, 0, 2'b10, 16'h0000, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 16'h1B1B, 0, 0);

    // random traffic on both channels
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r1, r2, r3, r4;
      r1 = $urandom; r2 = $urandom; r3 = $urandom; r4 = $urandom;
      step("R11", r1[1:0], r1[3:2], r1[5:4], r1[7:6], {r1[8] & r1[9] & r1[10], r1[11] & r1[12] & r1[13]},
           r2[15:0], r3[15:0] & 16'h8080, r4[15:0] & 16'h8080);
    end

    step("R10", 0, 0, 0, 0, 2'b11, 16'h0000, 0, 0);
    @(negedge clk);
    rx_set = 0; rx_clr = 0; tx_set = 0; tx_clr = 0; crst = 0;
    while (exp_pend_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule